// File: doc/BRIEF.md
# Over-Current Trip Integrator for a Half-Bridge Lamp Controller

This block decides when a half-bridge lamp controller has to stop switching because of excess current in its low-side leg. It only sees digital flags: a low-side gate-on flag, an over-current comparator flag, a two-bit operating-mode code, a supply-good flag and two shutdown-pin comparator flags. Each low-side conduction interval is graded as faulty or clean when it ends. An up/down event counter integrates those grades while the lamp is warming up or striking. Once the lamp is running, a single over-current sample during low-side conduction is enough to trip.

A trip sets a latched fault and inhibits the gates. The latch is released only by a lamp re-insertion on the shutdown pin: the pin first rises above its upper threshold and then falls below its lower threshold, while the supply is good. On release the block spends exactly one cycle in a restart state that asks the controller to go back to preheat. The control FSM has four states. `ST_COUNT` integrates in preheat or ignition. `ST_RUN` is single-event protection in run mode. `ST_FAULT` is the latched trip. `ST_RESTART` is the one-cycle preheat request.

The FSM takes these transitions. COUNT or RUN goes to FAULT on trip. COUNT goes to RUN, and RUN back to COUNT, when the mode code changes. FAULT goes to RESTART on release. RESTART goes to COUNT or RUN, following the mode code. A separate two-state re-insertion tracker (`ARM_IDLE`, `ARM_SEEN_HIGH`) runs only while the FSM is in `ST_FAULT`.

Top module: `ocp_fault_integrator`

## Requirements
- R1: After reset, `fault`, `gate_inhibit` and `preheat_req` are 0 and `event_count` is 0.
- R2: A low-side interval is graded at the clock edge where `lo_on` is sampled 0 after being sampled 1 at the previous edge. It is faulty if `oc_flag` was sampled 1 at any edge where `lo_on` was sampled 1 during that interval. `event_count` does not change before the interval is graded.
- R3: An `oc_flag` sample taken while `lo_on` is 0 has no effect on `event_count` or `fault`.
- R4: In preheat (`mode_code` 2'b00) or ignition (2'b01), outside a fault, a faulty interval raises `event_count` by exactly one.
- R5: In preheat or ignition, a clean interval lowers `event_count` by one, and the count stays at 0 when it is already 0.
- R6: When `event_count` reaches the trip count (default 100), `fault` goes to 1 at the same edge. The count then shows the trip value and never exceeds it.
- R7: In run mode (`mode_code[1]` = 1, so codes 2'b10 and 2'b11), any edge that samples `lo_on` and `oc_flag` both at 1 sets `fault` at that edge.
- R8: At any edge where run mode is sampled and no fault or restart is in progress, `event_count` becomes 0.
- R9: While `fault` is 1, `gate_inhibit` is 1, `event_count` holds its value, and over-current activity and mode changes are ignored.
- R10: A re-insertion consists of `sd_above_hi` sampled 1 during the fault, and later `sd_below_lo` sampled 1 while `supply_ok` is 1. It clears `fault`. For the next cycle `preheat_req` and `gate_inhibit` are 1 and `event_count` is 0, and after that both `preheat_req` and `gate_inhibit` return to 0.
- R11: During a fault, `sd_below_lo` without an earlier `sd_above_hi` has no effect. A below-low sample while `supply_ok` is 0 also does not release the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_on | input | 1 | Low-side gate is on |
| oc_flag | input | 1 | Current-sense comparator above its threshold |
| mode_code | input | 2 | 00 preheat, 01 ignition, 10 or 11 run |
| supply_ok | input | 1 | Supply above its under-voltage release level |
| sd_above_hi | input | 1 | Shutdown pin above its upper threshold |
| sd_below_lo | input | 1 | Shutdown pin below its lower threshold |
| fault | output | 1 | Latched over-current trip |
| gate_inhibit | output | 1 | Hold both gates off |
| preheat_req | output | 1 | One-cycle request to restart in preheat |
| event_count | output | 7 | Current value of the integrating counter |

## Verification
The checker assumes that the flags are synchronous to `clk` and held for whole cycles. It also assumes that the mode code does not make the counter step up at the same edge that clears it, and that the shutdown flags mean something only while a fault is latched. The stimulus changes every input only on the falling clock edge. It builds low-side intervals of several cycles, places over-current samples both inside and outside them, and drives the shutdown flags as separate one-cycle pulses. A behavioural model in the bench tracks state, counter and re-insertion progress and is compared with the outputs after every rising edge.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Operating mode as encoded on mode_code; bit 1 set means run.
    typedef enum logic [1:0] {
        MODE_PREHEAT  = 2'b00,
        MODE_IGNITION = 2'b01,
        MODE_RUN      = 2'b10,
        MODE_RUN_ALT  = 2'b11
    } op_mode_e;

    // Main control states.
    typedef enum logic [1:0] {
        ST_COUNT   = 2'd0,
        ST_RUN     = 2'd1,
        ST_FAULT   = 2'd2,
        ST_RESTART = 2'd3
    } ctl_state_e;

    // Shutdown-pin re-insertion tracker states.
    typedef enum logic {
        ARM_IDLE      = 1'b0,
        ARM_SEEN_HIGH = 1'b1
    } arm_state_e;

    function automatic logic is_run_mode(input logic [1:0] code);
        return code[1];
    endfunction

endpackage

// File: rtl/ocp_lo_cycle_monitor.sv
module ocp_lo_cycle_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_on,
    input  logic oc_flag,
    output logic cyc_end,
    output logic cyc_bad,
    output logic oc_now
);

    logic lo_q;
    logic oc_hold;

    // Interval ends where the gate flag is sampled low after being high.
    assign cyc_end = lo_q & ~lo_on;
    assign cyc_bad = oc_hold;
    assign oc_now  = lo_on & oc_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= 1'b0;
            oc_hold <= 1'b0;
        end else begin
            lo_q <= lo_on;
            if (cyc_end) begin
                oc_hold <= 1'b0;
            end else if (oc_now) begin
                oc_hold <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ocp_event_counter.sv
module ocp_event_counter #(
    parameter int CNT_W      = 7,
    parameter int TRIP_COUNT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             trip_hit
);

    localparam logic [CNT_W-1:0] TRIP_VAL = CNT_W'(TRIP_COUNT);
    localparam logic [CNT_W-1:0] TRIP_M1  = CNT_W'(TRIP_COUNT - 1);

    logic at_top;
    logic at_zero;

    assign at_top   = (count == TRIP_VAL);
    assign at_zero  = (count == '0);
    assign trip_hit = inc && (count == TRIP_M1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && !at_top) begin
            count <= count + 1'b1;
        end else if (dec && !at_zero) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/ocp_reinsert_tracker.sv
module ocp_reinsert_tracker
    import ocp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sd_above_hi,
    input  logic sd_below_lo,
    input  logic supply_ok,
    output logic release_ok
);

    arm_state_e arm_q;
    arm_state_e arm_d;

    assign release_ok = enable && (arm_q == ARM_SEEN_HIGH) && sd_below_lo && supply_ok;

    always_comb begin
        arm_d = arm_q;
        if (!enable) begin
            arm_d = ARM_IDLE;
        end else begin
            unique case (arm_q)
                ARM_IDLE:      if (sd_above_hi) arm_d = ARM_SEEN_HIGH;
                ARM_SEEN_HIGH: if (release_ok)  arm_d = ARM_IDLE;
                default:       arm_d = ARM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= ARM_IDLE;
        end else begin
            arm_q <= arm_d;
        end
    end

endmodule

// File: rtl/ocp_fault_integrator.sv
module ocp_fault_integrator
    import ocp_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int TRIP_COUNT = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_on,
    input  logic             oc_flag,
    input  logic [1:0]       mode_code,
    input  logic             supply_ok,
    input  logic             sd_above_hi,
    input  logic             sd_below_lo,
    output logic             fault,
    output logic             gate_inhibit,
    output logic             preheat_req,
    output logic [CNT_W-1:0] event_count
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    logic cyc_end;
    logic cyc_bad;
    logic oc_now;
    logic run_mode;
    logic active;
    logic cnt_clr;
    logic cnt_inc;
    logic cnt_dec;
    logic trip_hit;
    logic release_ok;

    assign run_mode = is_run_mode(mode_code);
    assign active   = (state_q == ST_COUNT) || (state_q == ST_RUN);

    ocp_lo_cycle_monitor u_lo_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_on   (lo_on),
        .oc_flag (oc_flag),
        .cyc_end (cyc_end),
        .cyc_bad (cyc_bad),
        .oc_now  (oc_now)
    );

    // Counter control: integrate only while active outside run mode.
    always_comb begin
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        cnt_dec = 1'b0;
        unique case (state_q)
            ST_COUNT, ST_RUN: begin
                if (run_mode) begin
                    cnt_clr = 1'b1;
                end else if (cyc_end) begin
                    cnt_inc = cyc_bad;
                    cnt_dec = !cyc_bad;
                end
            end
            ST_FAULT:   cnt_clr = release_ok;
            ST_RESTART: cnt_clr = 1'b1;
            default:    cnt_clr = 1'b1;
        endcase
    end

    ocp_event_counter #(
        .CNT_W      (CNT_W),
        .TRIP_COUNT (TRIP_COUNT)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .dec      (cnt_dec),
        .count    (event_count),
        .trip_hit (trip_hit)
    );

    ocp_reinsert_tracker u_reinsert (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (state_q == ST_FAULT),
        .sd_above_hi (sd_above_hi),
        .sd_below_lo (sd_below_lo),
        .supply_ok   (supply_ok),
        .release_ok  (release_ok)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT, ST_RUN: begin
                if (run_mode) begin
                    state_d = oc_now ? ST_FAULT : ST_RUN;
                end else begin
                    state_d = trip_hit ? ST_FAULT : ST_COUNT;
                end
            end
            ST_FAULT: begin
                if (release_ok) state_d = ST_RESTART;
            end
            ST_RESTART: begin
                state_d = run_mode ? ST_RUN : ST_COUNT;
            end
            default: state_d = ST_COUNT;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        fault        = 1'b0;
        gate_inhibit = 1'b0;
        preheat_req  = 1'b0;
        unique case (state_q)
            ST_COUNT, ST_RUN: ;
            ST_FAULT: begin
                fault        = 1'b1;
                gate_inhibit = 1'b1;
            end
            ST_RESTART: begin
                gate_inhibit = 1'b1;
                preheat_req  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ocp_fault_checker.sv
module ocp_fault_checker #(
    parameter int CNT_W      = 7,
    parameter int TRIP_COUNT = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lo_on,
    input logic             oc_flag,
    input logic [1:0]       mode_code,
    input logic             supply_ok,
    input logic             sd_above_hi,
    input logic             sd_below_lo,
    input logic             fault,
    input logic             gate_inhibit,
    input logic             preheat_req,
    input logic [CNT_W-1:0] event_count
);

    localparam logic [CNT_W-1:0] TRIP_VAL = CNT_W'(TRIP_COUNT);

    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (event_count > $past(event_count)) |-> (event_count == $past(event_count) + 1'b1));

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (event_count < $past(event_count)) |->
            ((event_count == $past(event_count) - 1'b1) || (event_count == '0)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        event_count <= TRIP_VAL);

    assert_trip_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault) && !$past(mode_code[1])) |-> (event_count == TRIP_VAL));

    assert_run_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code[1] && lo_on && oc_flag && !fault && !preheat_req) |=> fault);

    assert_run_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code[1] && !fault && !preheat_req) |=> (event_count == '0));

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault)) |-> ($stable(event_count) && gate_inhibit));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> preheat_req);

    assert_restart_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        preheat_req |-> (!fault && gate_inhibit && (event_count == '0)));

    assert_release_cond_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> $past(supply_ok && sd_below_lo));

endmodule

bind ocp_fault_integrator ocp_fault_checker #(
    .CNT_W      (CNT_W),
    .TRIP_COUNT (TRIP_COUNT)
) u_fault_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lo_on        (lo_on),
    .oc_flag      (oc_flag),
    .mode_code    (mode_code),
    .supply_ok    (supply_ok),
    .sd_above_hi  (sd_above_hi),
    .sd_below_lo  (sd_below_lo),
    .fault        (fault),
    .gate_inhibit (gate_inhibit),
    .preheat_req  (preheat_req),
    .event_count  (event_count)
);

// File: tb/ocp_fault_integrator_tb_top.sv
`timescale 1ns/1ps
module ocp_fault_integrator_tb_top;

    localparam int TRIP = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lo_on = 1'b0;
    logic       oc_flag = 1'b0;
    logic [1:0] mode_code = 2'b00;
    logic       supply_ok = 1'b1;
    logic       sd_above_hi = 1'b0;
    logic       sd_below_lo = 1'b0;
    logic       fault;
    logic       gate_inhibit;
    logic       preheat_req;
    logic [6:0] event_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ocp_fault_integrator dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .lo_on        (lo_on),
        .oc_flag      (oc_flag),
        .mode_code    (mode_code),
        .supply_ok    (supply_ok),
        .sd_above_hi  (sd_above_hi),
        .sd_below_lo  (sd_below_lo),
        .fault        (fault),
        .gate_inhibit (gate_inhibit),
        .preheat_req  (preheat_req),
        .event_count  (event_count)
    );

    // Behavioural reference: 0 counting, 1 running, 2 tripped, 3 restarting.
    int m_state = 0;
    int m_cnt = 0;
    bit m_armed = 0;
    bit m_prev_lo = 0;
    bit m_bad = 0;

    always @(posedge clk) begin
        bit ended;
        bit run;
        ended = m_prev_lo && !lo_on;
        run = mode_code[1];
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_armed = 0; m_prev_lo = 0; m_bad = 0;
        end else begin
            if (m_state == 2) begin
                if (m_armed && sd_below_lo && supply_ok) begin
                    m_state = 3; m_cnt = 0; m_armed = 0;
                end else if (sd_above_hi) begin
                    m_armed = 1;
                end
            end else if (m_state == 3) begin
                m_cnt = 0;
                m_state = run ? 1 : 0;
            end else if (run) begin
                m_cnt = 0;
                m_state = (lo_on && oc_flag) ? 2 : 1;
            end else begin
                m_state = 0;
                if (ended && m_bad) begin
                    if (m_cnt < TRIP) m_cnt++;
                    if (m_cnt == TRIP) m_state = 2;
                end else if (ended && m_cnt > 0) begin
                    m_cnt--;
                end
            end
            if (ended) m_bad = 0;
            else if (lo_on && oc_flag) m_bad = 1;
            m_prev_lo = lo_on;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, a quarter period after the edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            check("R4", "event_count", event_count, m_cnt);
            check("R6", "fault", fault, m_state == 2);
            check("R9", "gate_inhibit", gate_inhibit, (m_state == 2) || (m_state == 3));
            check("R10", "preheat_req", preheat_req, m_state == 3);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One low-side interval; oc_idx selects the on-cycle with over-current (-1 none).
    task automatic lo_cycle(input int on_len, input int oc_idx);
        for (int i = 0; i < on_len; i++) begin
            @(negedge clk);
            lo_on = 1'b1;
            oc_flag = (i == oc_idx);
        end
        @(negedge clk);
        lo_on = 1'b0;
        oc_flag = 1'b0;
        @(negedge clk);
    endtask

    task automatic reinsert();
        @(negedge clk); sd_above_hi = 1'b1;
        @(negedge clk); sd_above_hi = 1'b0;
        @(negedge clk); sd_below_lo = 1'b1;
        @(negedge clk); sd_below_lo = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1", "fault", fault, 0);
        check("R1", "event_count", event_count, 0);
        check("R1", "gate_inhibit", gate_inhibit, 0);
        check("R1", "preheat_req", preheat_req, 0);

        // R4: faulty intervals in preheat.
        for (int k = 0; k < 3; k++) lo_cycle(2, 1);
        check("R4", "event_count after three faulty intervals", event_count, 3);

        // R3: over-current while low side off.
        oc_flag = 1'b1;
        tick(3);
        oc_flag = 1'b0;
        tick(2);
        check("R3", "event_count with oc while off", event_count, 3);
        check("R3", "fault with oc while off", fault, 0);

        // R2: early sample remembered, graded only at the end.
        lo_on = 1'b1; oc_flag = 1'b1;
        tick(1);
        oc_flag = 1'b0;
        tick(2);
        check("R2", "event_count before grading", event_count, 3);
        lo_on = 1'b0;
        tick(1);
        check("R2", "event_count after grading", event_count, 4);

        // R5: clean intervals count down and saturate.
        for (int k = 0; k < 5; k++) lo_cycle(2, -1);
        check("R5", "event_count saturated at zero", event_count, 0);

        // R6: ignition, trip at the trip count.
        mode_code = 2'b01;
        for (int k = 0; k < TRIP - 1; k++) lo_cycle(1, 0);
        check("R6", "fault one short of trip", fault, 0);
        check("R6", "event_count one short", event_count, TRIP - 1);
        lo_cycle(1, 0);
        check("R6", "fault at trip", fault, 1);
        check("R6", "event_count at trip", event_count, TRIP);

        // R9: fault holds counter; mode change ignored.
        for (int k = 0; k < 3; k++) lo_cycle(2, 0);
        mode_code = 2'b10;
        tick(3);
        check("R9", "event_count held", event_count, TRIP);
        check("R9", "gate_inhibit held", gate_inhibit, 1);
        mode_code = 2'b00;

        // R11: below-low without above-high; release blocked by supply.
        sd_below_lo = 1'b1; tick(1); sd_below_lo = 1'b0; tick(1);
        check("R11", "fault after lone below-low", fault, 1);
        sd_above_hi = 1'b1; tick(1); sd_above_hi = 1'b0; tick(1);
        supply_ok = 1'b0;
        sd_below_lo = 1'b1; tick(1); sd_below_lo = 1'b0; tick(1);
        check("R11", "fault with supply low", fault, 1);
        supply_ok = 1'b1;

        // R10: release and one-cycle restart.
        sd_below_lo = 1'b1;
        tick(1);
        sd_below_lo = 1'b0;
        check("R10", "preheat_req in restart", preheat_req, 1);
        check("R10", "fault in restart", fault, 0);
        check("R10", "gate_inhibit in restart", gate_inhibit, 1);
        check("R10", "event_count in restart", event_count, 0);
        tick(1);
        check("R10", "preheat_req after restart", preheat_req, 0);
        check("R10", "gate_inhibit after restart", gate_inhibit, 0);

        // R8: entry into run clears the counter.
        for (int k = 0; k < 5; k++) lo_cycle(2, 0);
        check("R8", "event_count before run", event_count, 5);
        mode_code = 2'b10;
        tick(1);
        check("R8", "event_count after run entry", event_count, 0);

        // R7: run mode, single event trips; off-time oc ignored.
        oc_flag = 1'b1; tick(3); oc_flag = 1'b0;
        check("R7", "fault with oc while off in run", fault, 0);
        lo_on = 1'b1; oc_flag = 1'b1;
        tick(1);
        lo_on = 1'b0; oc_flag = 1'b0;
        check("R7", "fault after single event in run", fault, 1);
        check("R7", "event_count in run trip", event_count, 0);
        reinsert();
        check("R10", "fault after re-insertion", fault, 0);

        // R7: alternate run code.
        mode_code = 2'b11;
        tick(2);
        lo_cycle(3, 2);
        check("R7", "fault with code 11", fault, 1);
        reinsert();
        mode_code = 2'b00;
        tick(5);
        check("R10", "fault released again", fault, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule